// File: doc/BRIEF.md
# Two-Phase Bin Sort Sequencer

This block is the control unit of a bucket sort that runs in two passes over a set of leaf bins. A host programs it through a small register window. Writing the start bit launches phase one. In that phase the controller walks the bins in ascending order and asks the external memory to take each bin as a drain write. When the last bin is drained, or when the host forces the end of phase one, phase two begins. It goes through the bins again from index 0. For each bin it asks memory for a reload, then hands that bin to the external sorting datapath. It waits for that datapath to finish before it moves to the next bin. When the last bin is sorted, the controller raises a sticky completion flag, and the host polls for it.

The three request channels (drain, reload, sort) use valid/ready handshakes and share one bin index output. A request counts as taken in the cycle where valid and ready are both high. Once valid is raised, it stays high with the bin held stable until it is accepted. The only exceptions are the reset bit and the force bit. The ready side may hold ready low for as long as it likes. A new drain or reload request is only launched while the memory reports itself ready.

The controller counts accepted drain writes and accepted reloads, and the host can read both counts. It also picks a storage tier from the dataset size, and an override input can replace that choice. The tier is latched when a sort is accepted.

Top module: `sort2p_ctrl`

## Requirements
- R1: After `rst_n` is released, busy and done are 0, both counters read 0, and no request valid is high.
- R2: A register write to offset 0x00 with bit 0 set and bit 1 clear, while idle, makes busy read 1 from the next cycle. The same write clears both counters, clears done and starts phase one at bin 0.
- R3: In phase one, drain requests cover bins 0 to NUM_BINS-1 in ascending order. Each one holds valid and its bin stable until it is accepted. Each accepted drain adds 1 to the write counter.
- R4: Phase two covers bins 0 to NUM_BINS-1 in ascending order. For each bin it makes a reload request and then a sort request for the same bin. The next reload is not issued until the sort request is accepted. Each accepted reload adds 1 to the read counter.
- R5: When the sort request for the last bin is accepted, busy drops and done becomes 1 in the next cycle. Done stays 1 until a start is accepted or the reset bit is written.
- R6: A start write while busy is ignored. The counters, the bin index and the phase are unchanged.
- R7: Writing bit 1 of offset 0x00 returns the controller to idle, clears both counters and clears done. When bit 0 is set in the same write, bit 1 takes priority and no sort starts.
- R8: Writing bit 2 of offset 0x00 during phase one moves the controller, in the next cycle, to the reload of bin 0. A drain accepted in that same cycle is still counted. Outside phase one the bit has no effect.
- R9: A new drain or reload request is raised only while `mem_ready` is 1. Status bit 2 mirrors `mem_ready`.
- R10: The tier code is 0 for a size of 16 GB or less, 1 for a size of 64 GB or less, and 2 above 64 GB. When the override enable is high, the override code replaces it (code 3 maps to 2). The code is latched when a start is accepted, shown on `tier_sel` and in status bits 4:3, and cleared to 0 by the reset bit.
- R11: A read at offset 0x04 returns {tier, mem_ready, done, busy} in bits 4:0. Offset 0x10 returns the write count and 0x14 the read count. Any other offset, 0x00 included, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_ready | input | 1 | External memory ready to accept new requests |
| data_size_gb | input | SIZE_W | Dataset size in GB |
| tier_force_en | input | 1 | Use the override tier code |
| tier_force_sel | input | 2 | Override tier code |
| tier_sel | output | 2 | Latched tier code |
| drain_valid | output | 1 | Drain write request valid |
| drain_ready | input | 1 | Drain write request accepted |
| load_valid | output | 1 | Reload request valid |
| load_ready | input | 1 | Reload request accepted |
| sort_valid | output | 1 | Sort request valid |
| sort_ready | input | 1 | Sort of the bin finished / accepted |
| req_bin | output | BIN_W | Bin index of the active request |
| busy | output | 1 | A sort is in progress |
| done | output | 1 | Sticky sort-complete flag |

## Verification
The collision that matters is a host force of phase one's end landing in the same cycle that memory accepts a drain. The bench holds drain ready low after a start. In one cycle it then raises drain ready and writes the force bit together. It then judges that the write counter advanced by exactly one, that the drain request is gone, and that a reload for bin 0 is pending. It also checks the meeting of reset and start in one control write, which must leave the controller idle.

// File: rtl/sort2p_pkg.sv
package sort2p_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SCATTER = 2'd1,
    ST_LOAD    = 2'd2,
    ST_SORT    = 2'd3
  } seq_state_e;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_WCNT = 8'h10;
  localparam logic [7:0] OFS_RCNT = 8'h14;

  localparam int CTL_GO    = 0;
  localparam int CTL_CLEAR = 1;
  localparam int CTL_SKIP  = 2;

  localparam logic [1:0] TIER_FAST = 2'd0;
  localparam logic [1:0] TIER_MID  = 2'd1;
  localparam logic [1:0] TIER_SLOW = 2'd2;

endpackage

// File: rtl/sort2p_regif.sv
module sort2p_regif
  import sort2p_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             st_busy,
  input  logic             st_done,
  input  logic             st_mem_ready,
  input  logic [1:0]       st_tier,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic             cmd_start,
  output logic             cmd_clear,
  output logic             cmd_skip,
  output logic [31:0]      reg_rdata
);

  logic ctl_hit;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[31:3];
  assign ctl_hit   = reg_wr && (reg_addr == OFS_CTRL);
  // reset bit dominates the other control bits of the same write
  assign cmd_clear = ctl_hit && reg_wdata[CTL_CLEAR];
  assign cmd_start = ctl_hit && reg_wdata[CTL_GO]   && !reg_wdata[CTL_CLEAR];
  assign cmd_skip  = ctl_hit && reg_wdata[CTL_SKIP] && !reg_wdata[CTL_CLEAR];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_STAT: reg_rdata = {27'd0, st_tier, st_mem_ready, st_done, st_busy};
      OFS_WCNT: reg_rdata = 32'(wr_cnt);
      OFS_RCNT: reg_rdata = 32'(rd_cnt);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sort2p_tier.sv
module sort2p_tier
  import sort2p_pkg::*;
#(
  parameter int SIZE_W      = 16,
  parameter int FAST_MAX_GB = 16,
  parameter int MID_MAX_GB  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [SIZE_W-1:0] size_gb,
  input  logic              force_en,
  input  logic [1:0]        force_sel,
  output logic [1:0]        tier_q
);

  localparam logic [SIZE_W-1:0] FAST_LIM = SIZE_W'(FAST_MAX_GB);
  localparam logic [SIZE_W-1:0] MID_LIM  = SIZE_W'(MID_MAX_GB);

  logic [1:0] auto_tier;
  logic [1:0] pick;

  always_comb begin
    if (size_gb <= FAST_LIM)     auto_tier = TIER_FAST;
    else if (size_gb <= MID_LIM) auto_tier = TIER_MID;
    else                         auto_tier = TIER_SLOW;
  end

  always_comb begin
    if (force_en) pick = (force_sel == 2'd3) ? TIER_SLOW : force_sel;
    else          pick = auto_tier;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) tier_q <= TIER_FAST;
    else if (capture)    tier_q <= pick;
  end

  p_tier_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tier_q != 2'd3);

  p_tier_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !capture && !clear |=> $stable(tier_q));

endmodule

// File: rtl/sort2p_evcnt.sv
module sort2p_evcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (inc)        cnt_q <= cnt_q + CNT_W'(1);
  end

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !clear |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);

endmodule

// File: rtl/sort2p_seq.sv
module sort2p_seq
  import sort2p_pkg::*;
#(
  parameter int NUM_BINS = 8,
  parameter int BIN_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_clear,
  input  logic             cmd_skip,
  input  logic             mem_ready,
  input  logic             drain_ready,
  input  logic             load_ready,
  input  logic             sort_ready,
  output logic             drain_valid,
  output logic             load_valid,
  output logic             sort_valid,
  output logic [BIN_W-1:0] bin_q,
  output logic             busy,
  output logic             done_q,
  output logic             start_acc,
  output logic             drain_fire,
  output logic             load_fire
);

  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NUM_BINS - 1);

  seq_state_e state_q;
  logic       pend_q;
  logic       sort_fire;
  logic       at_last;
  logic       skip_now;

  assign busy      = (state_q != ST_IDLE);
  assign at_last   = (bin_q == LAST_BIN);
  assign start_acc = cmd_start && (state_q == ST_IDLE);
  assign skip_now  = cmd_skip && (state_q == ST_SCATTER);

  // launch only with memory ready; a raised request stays up until taken
  assign drain_valid = (state_q == ST_SCATTER) && (mem_ready || pend_q);
  assign load_valid  = (state_q == ST_LOAD)    && (mem_ready || pend_q);
  assign sort_valid  = (state_q == ST_SORT);

  assign drain_fire = drain_valid && drain_ready;
  assign load_fire  = load_valid  && load_ready;
  assign sort_fire  = sort_valid  && sort_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_clear) pend_q <= 1'b0;
    else pend_q <= (drain_valid && !drain_ready && !skip_now) ||
                   (load_valid && !load_ready);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_clear) begin
      state_q <= ST_IDLE;
      bin_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_start) begin
            state_q <= ST_SCATTER;
            bin_q   <= '0;
            done_q  <= 1'b0;
          end
        end
        ST_SCATTER: begin
          if (cmd_skip) begin
            state_q <= ST_LOAD;
            bin_q   <= '0;
          end else if (drain_fire) begin
            if (at_last) begin
              state_q <= ST_LOAD;
              bin_q   <= '0;
            end else begin
              bin_q <= bin_q + BIN_W'(1);
            end
          end
        end
        ST_LOAD: begin
          if (load_fire) state_q <= ST_SORT;
        end
        ST_SORT: begin
          if (sort_fire) begin
            if (at_last) begin
              state_q <= ST_IDLE;
              bin_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_LOAD;
              bin_q   <= bin_q + BIN_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_one_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drain_valid, load_valid, sort_valid}));

  p_drain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || cmd_clear)
    drain_valid && !drain_ready && !cmd_skip |=> drain_valid && $stable(bin_q));

  p_load_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || cmd_clear)
    load_valid && !load_ready |=> load_valid && $stable(bin_q));

  p_sort_follows_load_r4: assert property (@(posedge clk) disable iff (!rst_n || cmd_clear)
    load_fire |=> sort_valid && bin_q == $past(bin_q));

  p_bin_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bin_q <= LAST_BIN);

  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (!rst_n || cmd_clear)
    busy && cmd_start && !cmd_skip && !drain_fire && !load_fire && !sort_fire
      |=> $stable(bin_q) && $stable(state_q));

endmodule

// File: rtl/sort2p_ctrl.sv
module sort2p_ctrl #(
  parameter int NUM_BINS    = 8,
  parameter int CNT_W       = 32,
  parameter int SIZE_W      = 16,
  parameter int FAST_MAX_GB = 16,
  parameter int MID_MAX_GB  = 64,
  parameter int BIN_W       = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mem_ready,
  input  logic [SIZE_W-1:0] data_size_gb,
  input  logic              tier_force_en,
  input  logic [1:0]        tier_force_sel,
  output logic [1:0]        tier_sel,
  output logic              drain_valid,
  input  logic              drain_ready,
  output logic              load_valid,
  input  logic              load_ready,
  output logic              sort_valid,
  input  logic              sort_ready,
  output logic [BIN_W-1:0]  req_bin,
  output logic              busy,
  output logic              done
);

  localparam int NUM_CNT = 2;

  logic             cmd_start, cmd_clear, cmd_skip;
  logic             start_acc, drain_fire, load_fire;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [NUM_CNT];

  sort2p_regif #(.CNT_W(CNT_W)) u_regif (
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .st_busy      (busy),
    .st_done      (done),
    .st_mem_ready (mem_ready),
    .st_tier      (tier_sel),
    .wr_cnt       (cnt_val[0]),
    .rd_cnt       (cnt_val[1]),
    .cmd_start    (cmd_start),
    .cmd_clear    (cmd_clear),
    .cmd_skip     (cmd_skip),
    .reg_rdata    (reg_rdata)
  );

  sort2p_seq #(.NUM_BINS(NUM_BINS), .BIN_W(BIN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_clear   (cmd_clear),
    .cmd_skip    (cmd_skip),
    .mem_ready   (mem_ready),
    .drain_ready (drain_ready),
    .load_ready  (load_ready),
    .sort_ready  (sort_ready),
    .drain_valid (drain_valid),
    .load_valid  (load_valid),
    .sort_valid  (sort_valid),
    .bin_q       (req_bin),
    .busy        (busy),
    .done_q      (done),
    .start_acc   (start_acc),
    .drain_fire  (drain_fire),
    .load_fire   (load_fire)
  );

  sort2p_tier #(
    .SIZE_W(SIZE_W), .FAST_MAX_GB(FAST_MAX_GB), .MID_MAX_GB(MID_MAX_GB)
  ) u_tier (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cmd_clear),
    .capture   (start_acc),
    .size_gb   (data_size_gb),
    .force_en  (tier_force_en),
    .force_sel (tier_force_sel),
    .tier_q    (tier_sel)
  );

  assign cnt_inc = {load_fire, drain_fire};

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    sort2p_evcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cmd_clear || start_acc),
      .inc   (cnt_inc[gi]),
      .cnt_q (cnt_val[gi])
    );
  end

endmodule

// File: tb/tb_sort2p_ctrl.sv
module tb_sort2p_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int BW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_ready = 1'b0;
  logic [15:0] data_size_gb = 16'd0;
  logic        tier_force_en = 1'b0;
  logic [1:0]  tier_force_sel = 2'd0;
  logic [1:0]  tier_sel;
  logic        drain_valid, load_valid, sort_valid;
  logic        drain_ready = 1'b0, load_ready = 1'b0, sort_ready = 1'b0;
  logic [BW-1:0] req_bin;
  logic        busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int ev_n = 0;
  int ev_kind [256];
  int ev_bin  [256];
  bit finished = 0;

  sort2p_ctrl #(.NUM_BINS(NB), .BIN_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_ready(mem_ready),
    .data_size_gb(data_size_gb), .tier_force_en(tier_force_en),
    .tier_force_sel(tier_force_sel), .tier_sel(tier_sel),
    .drain_valid(drain_valid), .drain_ready(drain_ready),
    .load_valid(load_valid), .load_ready(load_ready),
    .sort_valid(sort_valid), .sort_ready(sort_ready),
    .req_bin(req_bin), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // handshake log, sampled mid-cycle: 1 drain, 2 reload, 3 sort
  always @(negedge clk) begin
    if (rst_n) begin
      if (drain_valid && drain_ready) begin ev_kind[ev_n % 256] = 1; ev_bin[ev_n % 256] = int'(req_bin); ev_n++; end
      if (load_valid && load_ready)   begin ev_kind[ev_n % 256] = 2; ev_bin[ev_n % 256] = int'(req_bin); ev_n++; end
      if (sort_valid && sort_ready)   begin ev_kind[ev_n % 256] = 3; ev_bin[ev_n % 256] = int'(req_bin); ev_n++; end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_ready(logic m, logic dr, logic lr, logic sr);
    mem_ready = m; drain_ready = dr; load_ready = lr; sort_ready = sr;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd_reg(8'h04, v); chk("R1", "status", v & 32'h3, 32'h0);
    rd_reg(8'h10, v); chk("R1", "wcnt", v, 0);
    rd_reg(8'h14, v); chk("R1", "rcnt", v, 0);
    chk("R1", "valids", {29'd0, drain_valid, load_valid, sort_valid}, 0);
    rd_reg(8'h00, v); chk("R11", "ctrl reads 0", v, 0);
    rd_reg(8'h08, v); chk("R11", "unmapped reads 0", v, 0);
  endtask

  task automatic t_full_sort;
    logic [31:0] v;
    int base, k;
    bit ok;
    set_ready(1, 1, 1, 1);
    data_size_gb = 16'd10;
    base = ev_n;
    wr_reg(8'h00, 32'h1);
    chk("R2", "busy after start", {31'd0, busy}, 1);
    k = 0;
    while (!done && k < 200) begin @(posedge clk); #2; k++; end
    chk("R5", "done reached", {31'd0, done}, 1);
    chk("R5", "busy dropped", {31'd0, busy}, 0);
    chk("R3", "event count", ev_n - base, 3 * NB);
    ok = 1;
    for (int i = 0; i < NB; i++)
      if (ev_kind[(base + i) % 256] != 1 || ev_bin[(base + i) % 256] != i) ok = 0;
    chk("R3", "drain order", {31'd0, ok}, 1);
    ok = 1;
    for (int b = 0; b < NB; b++) begin
      if (ev_kind[(base + NB + 2*b) % 256] != 2 || ev_bin[(base + NB + 2*b) % 256] != b) ok = 0;
      if (ev_kind[(base + NB + 2*b + 1) % 256] != 3 || ev_bin[(base + NB + 2*b + 1) % 256] != b) ok = 0;
    end
    chk("R4", "reload/sort order", {31'd0, ok}, 1);
    rd_reg(8'h10, v); chk("R11", "wcnt", v, NB);
    rd_reg(8'h14, v); chk("R4", "rcnt", v, NB);
    rd_reg(8'h04, v); chk("R11", "status", v, 32'h06);
    set_ready(1, 0, 0, 0);
    repeat (5) @(posedge clk); #2;
    chk("R5", "done sticky", {31'd0, done}, 1);
    wr_reg(8'h00, 32'h1);
    chk("R5", "start clears done", {30'd0, busy, done}, 32'h2);
    rd_reg(8'h10, v); chk("R2", "start clears wcnt", v, 0);
    chk("R2", "first drain bin 0", {30'd0, drain_valid, 1'b0} | 32'(req_bin), 32'h2);
    wr_reg(8'h00, 32'h2);
    chk("R7", "reset bit idles", {31'd0, busy}, 0);
  endtask

  task automatic t_backpressure;
    logic [31:0] v;
    set_ready(0, 0, 0, 0);
    wr_reg(8'h00, 32'h1);
    repeat (3) @(posedge clk); #2;
    chk("R9", "no drain without mem_ready", {31'd0, drain_valid}, 0);
    rd_reg(8'h04, v); chk("R9", "status mem_ready low", v & 32'h4, 0);
    mem_ready = 1'b1; #1;
    chk("R9", "drain raised", {31'd0, drain_valid}, 1);
    rd_reg(8'h04, v); chk("R9", "status mem_ready high", v & 32'h4, 32'h4);
    @(posedge clk); #2;
    mem_ready = 1'b0; #1;
    chk("R3", "drain held", {31'd0, drain_valid}, 1);
    chk("R3", "bin held", 32'(req_bin), 0);
    rd_reg(8'h10, v); chk("R3", "no count while stalled", v, 0);
    drain_ready = 1'b1;
    @(posedge clk); #2;
    drain_ready = 1'b0; #1;
    rd_reg(8'h10, v); chk("R3", "one accept counted", v, 1);
    chk("R3", "bin advanced", 32'(req_bin), 1);
    chk("R9", "next drain waits", {31'd0, drain_valid}, 0);
    wr_reg(8'h00, 32'h1);
    rd_reg(8'h10, v); chk("R6", "start while busy keeps wcnt", v, 1);
    chk("R6", "start while busy keeps bin", 32'(req_bin), 1);
    wr_reg(8'h00, 32'h2);
    rd_reg(8'h10, v); chk("R7", "reset clears wcnt", v, 0);
    chk("R7", "reset idles", {31'd0, busy}, 0);
    wr_reg(8'h00, 32'h3);
    chk("R7", "reset beats start", {31'd0, busy}, 0);
  endtask

  task automatic t_force;
    logic [31:0] v;
    set_ready(1, 0, 0, 0);
    wr_reg(8'h00, 32'h1);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h4; drain_ready = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_wdata = '0; drain_ready = 1'b0; #1;
    rd_reg(8'h10, v); chk("R8", "same-cycle drain counted", v, 1);
    chk("R8", "drain gone", {31'd0, drain_valid}, 0);
    chk("R8", "reload bin 0 pending", {31'd0, load_valid} | (32'(req_bin) << 4), 1);
    wr_reg(8'h00, 32'h4);
    chk("R8", "force ignored in reload", {31'd0, load_valid} | (32'(req_bin) << 4), 1);
    wr_reg(8'h00, 32'h2);
    wr_reg(8'h00, 32'h4);
    chk("R8", "force ignored while idle", {31'd0, busy}, 0);
  endtask

  task automatic tier_case(logic [15:0] sz, logic fe, logic [1:0] fs, logic [1:0] exp);
    logic [31:0] v;
    set_ready(0, 0, 0, 0);
    data_size_gb = sz; tier_force_en = fe; tier_force_sel = fs;
    wr_reg(8'h00, 32'h1);
    rd_reg(8'h04, v);
    chk("R10", $sformatf("tier size=%0d force=%0d/%0d", sz, fe, fs), (v >> 3) & 32'h3, 32'(exp));
    data_size_gb = 16'd1000; tier_force_en = 1'b0; #1;
    chk("R10", "tier latched at start", 32'(tier_sel), 32'(exp));
    wr_reg(8'h00, 32'h2);
  endtask

  task automatic t_tier;
    tier_case(16'd16, 0, 2'd0, 2'd0);
    tier_case(16'd17, 0, 2'd0, 2'd1);
    tier_case(16'd64, 0, 2'd0, 2'd1);
    tier_case(16'd65, 0, 2'd0, 2'd2);
    tier_case(16'd100, 1, 2'd0, 2'd0);
    tier_case(16'd1, 1, 2'd3, 2'd2);
    chk("R10", "reset bit clears tier", 32'(tier_sel), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_full_sort();
    t_backpressure();
    t_force();
    t_tier();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule